// File: doc/BRIEF.md
# Variable-Length Serial Master with Half-Duplex Data Option

This block is a synchronous serial bus master for a single attached slave. One start pulse shifts a programmed number of bits, anywhere from 1 to 32, out of a 32-bit transmit word. In the same transfer it gathers the same number of bits into a 32-bit receive word. The serial clock is the system clock divided by an even ratio between 2 and 256. The clock is only generated while a transfer is in flight. Clock idle level and sampling phase can each be chosen, which gives all four common clock modes.

A mode bit turns the outbound data pin into a half-duplex data line. A second bit then picks the direction: in one direction the master drives the line, in the other it only listens. The pin's output enable is brought out so that a pad can be built around it. Completion shows up as a sticky done flag, and the flag can be routed to an interrupt line.

Top module: `spi_len_master`

## Requirements
- R1: `len_m1` holds N-1, and each accepted start produces exactly N serial clock periods (2N `sck` transitions) before `ss_n` rises again.
- R2: Bits leave most-significant first. The first bit presented on `mosi` is `tx_data[N-1]` and the last is `tx_data[0]`; bits above N-1 have no effect.
- R3: At the end of a transfer, `rx_data` holds the N sampled bits right-aligned, with the last-sampled bit in bit 0 and zeros in bits 31..N.
- R4: `half_m1` holds H, and each half period of `sck` lasts H+1 system clocks, which gives division ratios 2..256. `ss_n` falls H+1 clocks before the first `sck` transition and rises H+1 clocks after the last one.
- R5: `sck` idles at `cpol`. With `cpha`=0, data is sampled on odd-numbered transitions (1, 3, ...) and the first bit is already valid before transition 1. With `cpha`=1, data changes on odd transitions and is sampled on even ones.
- R6: When `three_wire`=1, `miso` is ignored and input is taken from `mosi_in`. With `dir_tx`=1, `mosi_oe` is high for the whole transfer. With `dir_tx`=0, `mosi_oe` stays low from start to end.
- R7: When `three_wire`=0, `mosi_oe` is high, and input is sampled from `miso`.
- R8: `done` clears when a start is accepted. It sets in the cycle after the final sampling transition (transition 2N-1 for `cpha`=0, 2N for `cpha`=1) and holds until the next accepted start. `irq` equals `done` AND `irq_en`.
- R9: A `start` pulse while `busy` is high is ignored: the running transfer's length, timing, transmitted bits and result are unchanged.
- R10: While idle, `ss_n` is high and `sck` makes no transitions except to follow a change of `cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| len_m1 | input | 5 | Transfer length minus one |
| half_m1 | input | 7 | Half bit period in system clocks minus one |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Serial clock phase select |
| three_wire | input | 1 | Half-duplex single data line mode |
| dir_tx | input | 1 | Half-duplex direction: 1 drive, 0 listen |
| irq_en | input | 1 | Route done to irq |
| tx_data | input | 32 | Transmit word |
| rx_data | output | 32 | Received word, right-aligned |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | Completion interrupt |
| busy | output | 1 | Transfer in progress |
| sck | output | 1 | Serial clock |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Outbound data / half-duplex data out |
| mosi_oe | output | 1 | Output enable for the data pin |
| mosi_in | input | 1 | Pad read-back of the data pin |
| miso | input | 1 | Inbound data in full-duplex mode |

## Verification
The hardest case to reach from the ports is a second start arriving in the middle of a transfer. The pulse has to land on an edge where the design is busy, and the transmit word has to be altered at the same moment, so that any re-latch would show up. The bench raises that pulse a fixed number of clocks after slave select falls and flips the transmit bits at the same time. A slave model that reacts on every observed clock transition then checks that the bit stream, edge count and timing all match the original request. Half-duplex transmit is reached by looping the driven pin back into the read-back input, so the received word must equal the transmitted one.

// File: rtl/spi_len_master.sv
module spi_len_master #(
  parameter int DW = 32,
  parameter int HW = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [$clog2(DW)-1:0]  len_m1,
  input  logic [HW-1:0]          half_m1,
  input  logic                   cpol,
  input  logic                   cpha,
  input  logic                   three_wire,
  input  logic                   dir_tx,
  input  logic                   irq_en,
  input  logic [DW-1:0]          tx_data,
  output logic [DW-1:0]          rx_data,
  output logic                   done,
  output logic                   irq,
  output logic                   busy,
  output logic                   sck,
  output logic                   ss_n,
  output logic                   mosi,
  output logic                   mosi_oe,
  input  logic                   mosi_in,
  input  logic                   miso
);
  localparam int LW = $clog2(DW);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL} st_t;

  st_t           st;
  logic [HW-1:0] tmr, half_q;
  logic [LW:0]   ecnt;
  logic [LW-1:0] len_q;
  logic          pol_q, pha_q, tw_q, dir_q;
  logic          sck_r, dout, done_q;
  logic [DW-1:0] tx_sh, rx_sh, rx_q;

  logic [LW-1:0] sh_amt;
  logic [DW-1:0] aligned;
  assign sh_amt  = LW'(DW - 1) - len_m1;
  assign aligned = tx_data << sh_amt;

  logic tick, edge_ev, lead, smp, shf, last_edge, last_smp, din;
  assign tick      = (tmr == half_q);
  assign edge_ev   = (st == S_RUN) && tick;
  assign lead      = ~ecnt[0];
  assign smp       = edge_ev && (lead ^ pha_q);
  assign shf       = edge_ev && !(lead ^ pha_q);
  assign last_edge = (ecnt == {len_q, 1'b1});
  assign last_smp  = smp && (ecnt[LW:1] == len_q);
  assign din       = tw_q ? mosi_in : miso;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tmr    <= '0;
      half_q <= '0;
      ecnt   <= '0;
      len_q  <= '0;
      pol_q  <= 1'b0;
      pha_q  <= 1'b0;
      tw_q   <= 1'b0;
      dir_q  <= 1'b0;
      sck_r  <= 1'b0;
      dout   <= 1'b0;
      done_q <= 1'b0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      rx_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st     <= S_RUN;
          tmr    <= '0;
          ecnt   <= '0;
          len_q  <= len_m1;
          half_q <= half_m1;
          pol_q  <= cpol;
          pha_q  <= cpha;
          tw_q   <= three_wire;
          dir_q  <= dir_tx;
          sck_r  <= cpol;
          done_q <= 1'b0;
          rx_sh  <= '0;
          tx_sh  <= cpha ? aligned : (aligned << 1);
          dout   <= cpha ? 1'b0 : aligned[DW-1];
        end
        S_RUN: begin
          tmr <= tick ? '0 : tmr + 1'b1;
          if (tick) begin
            sck_r <= ~sck_r;
            ecnt  <= ecnt + 1'b1;
            if (last_edge) st <= S_TAIL;
          end
          if (shf) begin
            dout  <= tx_sh[DW-1];
            tx_sh <= tx_sh << 1;
          end
          if (smp) rx_sh <= {rx_sh[DW-2:0], din};
          if (last_smp) begin
            rx_q   <= {rx_sh[DW-2:0], din};
            done_q <= 1'b1;
          end
        end
        S_TAIL: begin
          tmr <= tick ? '0 : tmr + 1'b1;
          if (tick) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign ss_n    = ~busy;
  assign sck     = busy ? sck_r : cpol;
  assign mosi    = dout & (~tw_q | dir_q);
  assign mosi_oe = busy ? (~tw_q | dir_q) : ~three_wire;
  assign done    = done_q;
  assign irq     = done_q & irq_en;
  assign rx_data = rx_q;
endmodule

module spi_len_master_chk #(
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          ss_n,
  input logic          sck,
  input logic          sck_r,
  input logic          cpol,
  input logic          pol_q,
  input logic          tw_q,
  input logic          dir_q,
  input logic          mosi_oe,
  input logic          done,
  input logic          irq,
  input logic [LW-1:0] len_q
);
  // R6
  rx_line_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tw_q && !dir_q |-> !mosi_oe);

  // R8
  done_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !ss_n);

  // R8
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  // R1
  even_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> sck_r == pol_q);

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(len_q) && !$rose(ss_n) || $rose(ss_n));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n && $past(ss_n) && $stable(cpol) |-> $stable(sck));
endmodule

bind spi_len_master spi_len_master_chk #(.LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .ss_n(ss_n),
  .sck(sck), .sck_r(sck_r), .cpol(cpol), .pol_q(pol_q), .tw_q(tw_q),
  .dir_q(dir_q), .mosi_oe(mosi_oe), .done(done), .irq(irq), .len_q(len_q)
);

// File: tb/spi_len_master_tb.sv
module spi_len_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 1'b0;
  logic [4:0]  len_m1 = '0;
  logic [6:0]  half_m1 = '0;
  logic        cpol = 1'b0, cpha = 1'b0, three_wire = 1'b0, dir_tx = 1'b0, irq_en = 1'b0;
  logic [31:0] tx_data = '0;
  logic [31:0] rx_data;
  logic        done, irq, busy, sck, ss_n, mosi, mosi_oe;
  logic        slave_bit = 1'b0;
  logic        mosi_in, miso;

  assign miso    = three_wire ? ~slave_bit : slave_bit;
  assign mosi_in = (three_wire && dir_tx) ? (mosi_oe ? mosi : 1'b0) : slave_bit;

  spi_len_master dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .len_m1(len_m1), .half_m1(half_m1),
    .cpol(cpol), .cpha(cpha), .three_wire(three_wire), .dir_tx(dir_tx),
    .irq_en(irq_en), .tx_data(tx_data), .rx_data(rx_data), .done(done),
    .irq(irq), .busy(busy), .sck(sck), .ss_n(ss_n), .mosi(mosi),
    .mosi_oe(mosi_oe), .mosi_in(mosi_in), .miso(miso)
  );

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  typedef struct packed {
    logic [5:0]  n;
    logic [6:0]  h;
    logic        pol, pha, tw, dir, ien, ms;
    logic [31:0] tx, sw;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{6'd8,  7'd0,   1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_00A5, 32'h0000_003C},
    '{6'd8,  7'd1,   1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_005A, 32'h0000_00C3},
    '{6'd32, 7'd0,   1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'hDEAD_BEEF, 32'h1234_5678},
    '{6'd1,  7'd2,   1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001},
    '{6'd13, 7'd3,   1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'hFFFF_A5A5, 32'hFFFF_1234},
    '{6'd16, 7'd0,   1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_BEEF, 32'h0000_0000},
    '{6'd12, 7'd1,   1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0FFF, 32'h0000_0ABC},
    '{6'd5,  7'd127, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0013, 32'h0000_000A},
    '{6'd4,  7'd3,   1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0009, 32'h0000_0006}
  };

  task automatic run(input vec_t v);
    int n, h, t, edges, nd, t_first, t_done;
    logic bad_time, bad_oe, seen_done, prev;
    logic [31:0] cap, mask, exp_rx;
    n = int'(v.n); h = int'(v.h);
    mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
    @(negedge clk);
    len_m1 = 5'(n - 1); half_m1 = v.h; cpol = v.pol; cpha = v.pha;
    three_wire = v.tw; dir_tx = v.dir; irq_en = v.ien; tx_data = v.tx;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R8: done cleared by the accepted start
    chk(!done && !ss_n, "R8", {30'd0, done, ss_n}, 32'd0);
    nd = 0;
    if (!v.pha) begin slave_bit = v.sw[n-1]; nd = 1; end
    t = 0; edges = 0; cap = '0; bad_time = 0; bad_oe = 0;
    seen_done = 0; t_done = -1; t_first = -1; prev = sck;
    while (!ss_n && t < 40000) begin
      if (v.ms && t == 5) begin start = 1'b1; tx_data = ~v.tx; end
      else start = 1'b0;
      @(negedge clk);
      t++;
      if (!ss_n) begin
        if (v.tw && !v.dir && mosi_oe) bad_oe = 1;
        if (!(v.tw && !v.dir) && !mosi_oe) bad_oe = 1;
      end
      if (done && !seen_done) begin seen_done = 1; t_done = t; end
      if (sck != prev) begin
        edges++;
        if (t_first < 0) t_first = t;
        if (t != edges * (h + 1)) bad_time = 1;
        if ((edges % 2 == 1) != v.pha) cap = {cap[30:0], mosi};
        else if (nd < n) begin slave_bit = v.sw[n-1-nd]; nd++; end
      end
      prev = sck;
    end
    start = 1'b0;
    exp_rx = (v.tw && v.dir) ? (v.tx & mask) : (v.sw & mask);
    chk(edges == 2 * n, "R1", edges, 2 * n);
    if (!(v.tw && !v.dir)) chk(cap == (v.tx & mask), "R2", cap, v.tx & mask);
    chk(rx_data == exp_rx, "R3", rx_data, exp_rx);
    chk(!bad_time && t_first == h + 1, "R4 lead/edge spacing", t_first, h + 1);
    chk(t == (2 * n + 1) * (h + 1), "R4 tail", t, (2 * n + 1) * (h + 1));
    chk(sck == v.pol, "R5 idle level", sck, v.pol);
    chk(!bad_oe, v.tw ? "R6 oe" : "R7 oe", bad_oe, 0);
    chk(t_done == (v.pha ? 2 * n : 2 * n - 1) * (h + 1), "R8 done time",
        t_done, (v.pha ? 2 * n : 2 * n - 1) * (h + 1));
    chk(done && irq == v.ien, "R8 irq", {30'd0, done, irq}, {30'd0, 1'b1, v.ien});
    if (v.ms) chk(cap == (v.tx & mask) && edges == 2 * n, "R9", cap, v.tx & mask);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ss_n && !sck && !done && !irq && !busy && rx_data == 0, "R10 reset",
        {26'd0, ss_n, sck, done, irq, busy, 1'b0}, 32'h20);
    chk(mosi_oe, "R7 reset oe", mosi_oe, 1);
    rst_n = 1'b1;
    @(negedge clk);
    cpol = 1'b1;
    @(negedge clk);
    chk(sck == 1'b1 && ss_n, "R10 idle follows cpol", sck, 1);
    cpol = 1'b0;
    @(negedge clk);
    chk(sck == 1'b0, "R5 idle low", sck, 0);

    for (int i = 0; i < 9; i++) run(VECS[i]);

    begin
      logic moved;
      logic [31:0] keep;
      moved = 0; keep = rx_data;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (sck != 1'b0 || !ss_n) moved = 1;
      end
      chk(!moved, "R10 idle quiet", moved, 0);
      chk(rx_data == keep && done, "R8 sticky", rx_data, keep);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule